// File: doc/BRIEF.md
# Packed SIMD Shift and Compare Unit

This block is a 64-bit logic-unit datapath stage. It treats its first source as a packed vector of either two 32-bit lanes or four 16-bit lanes and shifts every lane by one shared amount taken from the second source. Three shift kinds are available: arithmetic right, logical right and left. Each lane is shifted on its own, so no bit moves into a neighbouring lane.

The same stage can also compare the four signed 16-bit lanes of both sources, for greater-than or for equality, and pack the four results as a bit mask at the bottom of the result. A mask expander does the reverse: it turns four bits of the first source into four 16-bit lanes that are all ones or all zeros. The mask from a compare can therefore be fed back through the expander to get a lane select mask for a later merge.

The result is registered, so it appears one clock after the operands and opcode are presented. A new operation can be issued on every cycle.

Top module: `simd_shcmp_unit`

## Requirements
- R1: While rst_n is low, res_o is all zeros.
- R2: The result of the operands and opcode sampled on a rising clock edge appears on res_o right after that edge and holds until the next edge; inputs changed between edges do not affect res_o before the next edge.
- R3: Opcode 0 shifts each 32-bit lane of src_a_i (lane 0 in bits 31:0, lane 1 in bits 63:32) right by src_b_i[4:0] and fills the vacated bits with that lane's own bit 31.
- R4: Opcode 1 shifts each 32-bit lane of src_a_i right by src_b_i[4:0] and fills the vacated bits with zeros.
- R5: Opcode 2 shifts each 32-bit lane of src_a_i left by src_b_i[4:0] and fills the vacated bits with zeros.
- R6: Opcodes 3, 4 and 5 shift each 16-bit lane of src_a_i (lane i in bits 16i+15:16i) by src_b_i[3:0]: arithmetic right with the lane's bit 15 as fill, logical right, and left.
- R7: Opcode 6 sets res_o bit i to 1 exactly when lane i of src_a_i is greater than lane i of src_b_i, both as signed 16-bit values; res_o bits 63:4 are zero.
- R8: Opcode 7 sets res_o bit i to 1 exactly when lane i of src_a_i equals lane i of src_b_i; res_o bits 63:4 are zero.
- R9: Opcode 8 sets 16-bit lane i of res_o to 0xFFFF when src_a_i bit i is 1 and to 0x0000 when it is 0, for i from 0 to 3; src_a_i bits 63:4 and src_b_i have no effect.
- R10: Opcodes 9 to 15 give an all-zero res_o.
- R11: For shifts, the bits of src_b_i above the shift amount field (bits 63:5 for 32-bit lanes, bits 63:4 for 16-bit lanes) have no effect; an amount field of zero returns src_a_i unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation select, codes as in the requirements |
| src_a_i | input | 64 | Packed data operand, compare left side, expander bits |
| src_b_i | input | 64 | Shift amount source, compare right side |
| res_o | output | 64 | Registered result |

## Verification
On every cycle the assertions check the reset value, that compare results leave bits 63:4 clear, that the expander yields only all-ones or all-zero lanes matching the sampled bits, that a zero shift amount passes the operand through, and that unused opcodes give zero. The exact lane arithmetic of each shift kind, the sign fill of the arithmetic shifts at the lane edges, signed ordering at the 0x8000 and 0x7FFF extremes, and the one-cycle timing are shown only by the bench's directed corner cases and its seeded random operations compared against a bit-level reference model.

// File: rtl/simd_shcmp_pkg.sv
package simd_shcmp_pkg;

  localparam int WORD_W   = 64;
  localparam int WIDE_W   = 32;
  localparam int NARROW_W = 16;
  localparam int OP_W     = 4;
  localparam int NCMP     = WORD_W / NARROW_W;

  typedef enum logic [OP_W-1:0] {
    OP_SRA32 = 4'd0,
    OP_SRL32 = 4'd1,
    OP_SLL32 = 4'd2,
    OP_SRA16 = 4'd3,
    OP_SRL16 = 4'd4,
    OP_SLL16 = 4'd5,
    OP_CGT16 = 4'd6,
    OP_CEQ16 = 4'd7,
    OP_XPND  = 4'd8
  } op_e;

  typedef enum logic [1:0] {
    SH_ARITH = 2'd0,
    SH_LOGIC = 2'd1,
    SH_LEFT  = 2'd2
  } shmode_e;

endpackage

// File: rtl/simd_lane_shift.sv
module simd_lane_shift #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 32
) (
  input  logic [DATA_W-1:0]         data_i,
  input  logic [$clog2(LANE_W)-1:0] amt_i,
  input  simd_shcmp_pkg::shmode_e   mode_i,
  output logic [DATA_W-1:0]         data_o
);
  import simd_shcmp_pkg::*;

  localparam int NLANES = DATA_W / LANE_W;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_in;
    logic [LANE_W-1:0] lane_out;

    assign lane_in = data_i[g*LANE_W +: LANE_W];

    always_comb begin
      case (mode_i)
        SH_ARITH: lane_out = $signed(lane_in) >>> amt_i;
        SH_LOGIC: lane_out = lane_in >> amt_i;
        default:  lane_out = lane_in << amt_i;
      endcase
    end

    assign data_o[g*LANE_W +: LANE_W] = lane_out;
  end

endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16
) (
  input  logic [DATA_W-1:0]        a_i,
  input  logic [DATA_W-1:0]        b_i,
  output logic [DATA_W/LANE_W-1:0] gt_o,
  output logic [DATA_W/LANE_W-1:0] eq_o
);
  localparam int NLANES = DATA_W / LANE_W;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic signed [LANE_W-1:0] la;
    logic signed [LANE_W-1:0] lb;
    assign la = a_i[g*LANE_W +: LANE_W];
    assign lb = b_i[g*LANE_W +: LANE_W];
    assign gt_o[g] = la > lb;
    assign eq_o[g] = la == lb;
  end

  // R7 R8: a lane cannot be both greater and equal
  always_comb begin
    gt_eq_excl_chk: assert ((gt_o & eq_o) == '0);
  end

endmodule

// File: rtl/simd_mask_expand.sv
module simd_mask_expand #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16
) (
  input  logic [DATA_W/LANE_W-1:0] bits_i,
  output logic [DATA_W-1:0]        mask_o
);
  localparam int NLANES = DATA_W / LANE_W;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign mask_o[g*LANE_W +: LANE_W] = {LANE_W{bits_i[g]}};
  end

endmodule

// File: rtl/simd_shcmp_unit.sv
module simd_shcmp_unit
  import simd_shcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_i,
  input  logic [WORD_W-1:0] src_a_i,
  input  logic [WORD_W-1:0] src_b_i,
  output logic [WORD_W-1:0] res_o
);

  localparam int AMT_WIDE_W   = $clog2(WIDE_W);
  localparam int AMT_NARROW_W = $clog2(NARROW_W);

  op_e               op;
  shmode_e           sh_mode;
  logic [WORD_W-1:0] wide_res;
  logic [WORD_W-1:0] narrow_res;
  logic [NCMP-1:0]   cmp_gt;
  logic [NCMP-1:0]   cmp_eq;
  logic [WORD_W-1:0] xpnd_res;
  logic [WORD_W-1:0] res_d;
  logic [WORD_W-1:0] res_q;

  assign op = op_e'(op_i);

  always_comb begin
    case (op)
      OP_SRA32, OP_SRA16: sh_mode = SH_ARITH;
      OP_SRL32, OP_SRL16: sh_mode = SH_LOGIC;
      default:            sh_mode = SH_LEFT;
    endcase
  end

  simd_lane_shift #(.DATA_W(WORD_W), .LANE_W(WIDE_W)) u_shift_wide (
    .data_i (src_a_i),
    .amt_i  (src_b_i[AMT_WIDE_W-1:0]),
    .mode_i (sh_mode),
    .data_o (wide_res)
  );

  simd_lane_shift #(.DATA_W(WORD_W), .LANE_W(NARROW_W)) u_shift_narrow (
    .data_i (src_a_i),
    .amt_i  (src_b_i[AMT_NARROW_W-1:0]),
    .mode_i (sh_mode),
    .data_o (narrow_res)
  );

  simd_lane_cmp #(.DATA_W(WORD_W), .LANE_W(NARROW_W)) u_cmp (
    .a_i  (src_a_i),
    .b_i  (src_b_i),
    .gt_o (cmp_gt),
    .eq_o (cmp_eq)
  );

  simd_mask_expand #(.DATA_W(WORD_W), .LANE_W(NARROW_W)) u_xpnd (
    .bits_i (src_a_i[NCMP-1:0]),
    .mask_o (xpnd_res)
  );

  // next-state selection
  always_comb begin
    res_d = '0;
    case (op)
      OP_SRA32, OP_SRL32, OP_SLL32: res_d = wide_res;
      OP_SRA16, OP_SRL16, OP_SLL16: res_d = narrow_res;
      OP_CGT16:                     res_d = {{(WORD_W-NCMP){1'b0}}, cmp_gt};
      OP_CEQ16:                     res_d = {{(WORD_W-NCMP){1'b0}}, cmp_eq};
      OP_XPND:                      res_d = xpnd_res;
      default:                      res_d = '0;
    endcase
  end

  // result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  assign res_o = res_q;

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |-> res_o == '0);

  // R7
  cmp_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CGT16 || op_i == OP_CEQ16) |=> res_o[WORD_W-1:NCMP] == '0);

  // R9
  xpnd_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == OP_XPND |=> (res_o[15:0]  == {16{$past(src_a_i[0])}}) &&
                        (res_o[31:16] == {16{$past(src_a_i[1])}}) &&
                        (res_o[47:32] == {16{$past(src_a_i[2])}}) &&
                        (res_o[63:48] == {16{$past(src_a_i[3])}}));

  // R11
  shift_zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i <= OP_SLL32 && src_b_i[4:0] == '0) ||
     (op_i >= OP_SRA16 && op_i <= OP_SLL16 && src_b_i[3:0] == '0))
    |=> res_o == $past(src_a_i));

  // R10
  bad_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_i > OP_XPND |=> res_o == '0);

endmodule

// File: tb/simd_shcmp_unit_bench.sv
`timescale 1ns/1ps
module simd_shcmp_unit_bench;

  logic        clk;
  logic        rst_n;
  logic [3:0]  op_i;
  logic [63:0] src_a_i;
  logic [63:0] src_b_i;
  logic [63:0] res_o;

  int n_cmp;
  int n_bad;
  int cycles;

  simd_shcmp_unit u_simd_shcmp_unit (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .src_a_i (src_a_i),
    .src_b_i (src_b_i),
    .res_o   (res_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // bit-level lane shift; kind 0 arith right, 1 logical right, 2 left
  function automatic logic [63:0] ref_shift(logic [63:0] a, int w, int sh, int kind);
    logic [63:0] r;
    r = '0;
    for (int l = 0; l < 64 / w; l++) begin
      for (int k = 0; k < w; k++) begin
        int base;
        base = l * w;
        if (kind == 2) r[base+k] = (k >= sh) ? a[base+k-sh] : 1'b0;
        else if (k + sh < w) r[base+k] = a[base+k+sh];
        else r[base+k] = (kind == 0) ? a[base+w-1] : 1'b0;
      end
    end
    return r;
  endfunction

  function automatic logic [63:0] ref_model(logic [3:0] op, logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    r = '0;
    case (op)
      4'd0, 4'd1, 4'd2: r = ref_shift(a, 32, int'(b[4:0]), int'(op));
      4'd3, 4'd4, 4'd5: r = ref_shift(a, 16, int'(b[3:0]), int'(op) - 3);
      4'd6: for (int i = 0; i < 4; i++) begin
              int sa, sb;
              sa = int'($signed(a[i*16 +: 16]));
              sb = int'($signed(b[i*16 +: 16]));
              r[i] = sa > sb;
            end
      4'd7: for (int i = 0; i < 4; i++) r[i] = a[i*16 +: 16] == b[i*16 +: 16];
      4'd8: for (int i = 0; i < 4; i++) r[i*16 +: 16] = a[i] ? 16'hFFFF : 16'h0000;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string op_req(logic [3:0] op);
    case (op)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3, 4'd4, 4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at falling edge, sample at the next falling edge (one register)
  task automatic run(string req, logic [3:0] op, logic [63:0] a, logic [63:0] b);
    op_i = op; src_a_i = a; src_b_i = b;
    @(negedge clk);
    check(req, res_o, ref_model(op, a, b));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [63:0] hold;
    n_cmp = 0; n_bad = 0; cycles = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; op_i = 4'd8; src_a_i = '1; src_b_i = '1;
    repeat (3) @(negedge clk);
    check("R1", res_o, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 sign fill per lane, max amount, lane edges
    run("R3", 4'd0, 64'h8000_0000_7FFF_FFFF, 64'd31);
    run("R3", 4'd0, 64'hF000_1234_0F00_8765, 64'd4);
    // R4
    run("R4", 4'd1, 64'h8000_0000_FFFF_FFFF, 64'd31);
    // R5 bits must not cross into the upper lane
    run("R5", 4'd2, 64'h0000_0001_FFFF_FFFF, 64'd8);
    // R6 each 16-bit variant
    run("R6", 4'd3, 64'h8000_7FFF_F00F_0001, 64'd15);
    run("R6", 4'd4, 64'h8000_7FFF_F00F_0001, 64'd3);
    run("R6", 4'd5, 64'h8001_7FFF_F00F_0001, 64'd15);
    // R11 upper amount bits ignored, zero field passes through
    run("R11", 4'd0, 64'hDEAD_BEEF_8000_0001, 64'hFFFF_FFFF_FFFF_FFE0);
    run("R11", 4'd3, 64'hDEAD_BEEF_8000_0001, 64'hFFFF_FFFF_FFFF_FFF0);
    run("R11", 4'd1, 64'hDEAD_BEEF_8000_0001, 64'hAAAA_AAAA_AAAA_AA43);
    // R7 signed extremes and equal lanes
    run("R7", 4'd6, 64'h7FFF_8000_0005_FFFF, 64'h8000_7FFF_0005_0000);
    run("R7", 4'd6, 64'h0001_FFFE_1234_8001, 64'h0000_FFFF_1234_8000);
    // R8
    run("R8", 4'd7, 64'h1234_8000_FFFF_0000, 64'h1234_8001_FFFF_0000);
    // R9 upper bits of src_a_i and src_b_i ignored
    run("R9", 4'd8, 64'hFFFF_FFFF_FFFF_FFF5, 64'h1234_5678_9ABC_DEF0);
    run("R9", 4'd8, 64'h0000_0000_0000_000A, 64'h0);
    // R10
    for (int o = 9; o < 16; o++) run("R10", 4'(o), '1, '1);

    // R2: a change between edges must not reach res_o before the next edge
    run("R2", 4'd8, 64'h3, 64'h0);
    hold = res_o;
    #1 src_a_i = 64'hC; op_i = 4'd8;
    #0.5 check("R2", res_o, hold);
    @(negedge clk);
    check("R2", res_o, ref_model(4'd8, 64'hC, 64'h0));

    // random mix
    for (int n = 0; n < 2000; n++) begin
      logic [3:0]  op;
      logic [63:0] a, b;
      op = 4'($urandom_range(0, 9));
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (op >= 4'd6 && op <= 4'd7 && $urandom_range(0, 3) == 0)
        b[31:16] = a[31:16];
      run(op_req(op), op, a, b);
    end

    // R1 asynchronous reset mid-run
    op_i = 4'd8; src_a_i = 64'hF;
    @(negedge clk);
    rst_n = 1'b0;
    #0.5 check("R1", res_o, 64'h0);
    rst_n = 1'b1;
    finish_run();
  end

endmodule